// File: doc/BRIEF.md
# Indirect-Select Vectored Interrupt Controller

This block collects up to 128 interrupt request lines and presents one interrupt output to a processor. Software reaches every source through a single index: it writes the source number into a select register, and then the mode, vector and command registers that follow all act on that source alone. Each source has its own priority (0 to 7), trigger type and 32-bit vector. The block picks the highest-priority pending enabled source and raises its output when that source outranks the interrupt currently being serviced.

Servicing is nested. When the processor reads the acknowledge register, it gets the winning source's vector, and the source's priority and index go onto an eight-level stack. Only a strictly higher priority can interrupt again until a write to the end-of-interrupt register pops the level. When nothing qualifies, the acknowledge read returns a software-programmed spurious value and nothing is stacked. A 32-bit debug control word is kept as plain storage.

Top module: `vic_top`

## Requirements
- R1: After synchronous reset every source is disabled, with its mode, vector and pending flag at zero. The stack is empty, irq_out is low and the acknowledge read (0x10) returns the spurious value, which resets to 0.
- R2: Offset 0x00 holds a 7-bit source index taken from write bits [6:0]. Offsets 0x04 (mode) and 0x08 (vector) read and write the selected source's own copy. Mode bits [2:0] are the priority and bits [6:5] are the trigger: 00 high level, 01 low level, 10 rising edge, 11 falling edge. All other mode bits read 0.
- R3: A write with bit 0 set acts on the selected source: 0x40 enables it, 0x44 disables it, 0x48 clears its stored pending flag and 0x4C sets it. A write with bit 0 clear has no effect. Offset 0x30 returns the selected source's enable in bit 0.
- R4: Offsets 0x20, 0x24, 0x28 and 0x2C return pending state for sources 0-31, 32-63, 64-95 and 96-127. Source n appears at bit n mod 32.
- R5: The inputs are registered once. A level source is pending while its registered input is at its active level. An edge source latches its flag on the clock edge where the input differs from its registered copy in the chosen direction. Both kinds become visible one cycle after the input changes.
- R6: irq_out is high exactly when some enabled pending source has a priority strictly above the stack top, or the stack is empty. A disabled source never raises it.
- R7: The acknowledge read at 0x10 returns the vector of the highest-priority enabled pending source, with the lowest index winning a tie. When irq_out is low it returns the spurious register at 0x3C.
- R8: An acknowledge read while irq_out is high pushes the winner's priority and index and clears its stored pending flag. Offset 0x18 returns the index on the stack top, or 0 when the stack is empty.
- R9: Any write to 0x38 pops one stack level. A pop on an empty stack is ignored, so eight such writes always leave the stack empty.
- R10: When an edge is detected on the same clock edge as a clear command or an acknowledge of that source, the pending flag stays set.
- R11: Offset 0x6C is a 32-bit read/write storage word. Unmapped offsets read 0 and ignore writes.
- R12: The stack never holds more than eight levels. When a priority-7 level is on top, the acknowledge read returns the spurious value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe; read side effects occur at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| irq_req | input | 128 | Request lines, one per source |
| irq_out | output | 1 | Interrupt output to the processor |

## Verification
Two functions can act on the same pending flag in the same cycle: a newly detected edge, and a clear, which comes either from the clear command or from the acknowledge read. The bench provokes this by holding a rising-edge source's flag set, dropping its line, and then raising it again in exactly the cycle of the acknowledge read, and in a second case in the cycle of the clear write. It then reads the pending word and expects the bit still set. Random traffic on a small set of sources mixes line toggles with acknowledges and clears, so the same collision also occurs in cycles the bench did not arrange.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [7:0] OFF_SEL   = 8'h00;
  localparam logic [7:0] OFF_MODE  = 8'h04;
  localparam logic [7:0] OFF_VEC   = 8'h08;
  localparam logic [7:0] OFF_ACK   = 8'h10;
  localparam logic [7:0] OFF_CUR   = 8'h18;
  localparam logic [7:0] OFF_PND0  = 8'h20;
  localparam logic [7:0] OFF_PND1  = 8'h24;
  localparam logic [7:0] OFF_PND2  = 8'h28;
  localparam logic [7:0] OFF_PND3  = 8'h2C;
  localparam logic [7:0] OFF_ENRD  = 8'h30;
  localparam logic [7:0] OFF_EOI   = 8'h38;
  localparam logic [7:0] OFF_SPUR  = 8'h3C;
  localparam logic [7:0] OFF_ENA   = 8'h40;
  localparam logic [7:0] OFF_DIS   = 8'h44;
  localparam logic [7:0] OFF_CLR   = 8'h48;
  localparam logic [7:0] OFF_SET   = 8'h4C;
  localparam logic [7:0] OFF_DBG   = 8'h6C;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef struct packed {
    trig_e      trig;
    logic [2:0] prio;
  } src_mode_t;

  // level sources: active level seen on the registered input
  function automatic logic lvl_hit(trig_e t, logic q);
    return (t == TRIG_HIGH && q) || (t == TRIG_LOW && !q);
  endfunction

  // edge sources: raw input against its registered copy
  function automatic logic edge_hit(trig_e t, logic now, logic q);
    return (t == TRIG_RISE && now && !q) || (t == TRIG_FALL && !now && q);
  endfunction

  function automatic src_mode_t word_to_mode(logic [6:0] w);
    src_mode_t m;
    m.trig = trig_e'(w[6:5]);
    m.prio = w[2:0];
    return m;
  endfunction

  function automatic logic [31:0] mode_to_word(src_mode_t m);
    return {25'b0, m.trig, 2'b00, m.prio};
  endfunction

  // a candidate preempts only when strictly above the level in service
  function automatic logic prio_beats(logic [2:0] p, logic stk_empty, logic [2:0] top);
    return stk_empty || (p > top);
  endfunction
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank
  import vic_pkg::*;
#(
  parameter int NSRC = 128,
  parameter int DW   = 32,
  parameter int IDXW = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       irq_req,
  input  logic [6:0]            sel,
  input  logic [DW-1:0]         wdata,
  input  logic                  wr_mode,
  input  logic                  wr_vec,
  input  logic                  cmd_en,
  input  logic                  cmd_dis,
  input  logic                  cmd_clr,
  input  logic                  cmd_set,
  input  logic                  ack,
  input  logic [IDXW-1:0]       ack_idx,
  input  logic [IDXW-1:0]       win_idx,
  output logic [NSRC-1:0]       pend,
  output logic [NSRC-1:0]       en,
  output logic [NSRC-1:0][2:0]  prio,
  output src_mode_t             sel_mode,
  output logic [DW-1:0]         sel_vec,
  output logic                  sel_en,
  output logic [DW-1:0]         win_vec
);
  src_mode_t         mode_q [NSRC];
  logic [DW-1:0]     vec_q  [NSRC];
  logic [NSRC-1:0]   en_q, flag_q, in_q;
  logic [NSRC-1:0]   edge_seen, lvl_on, sel_hot, ack_hot;
  logic              sel_ok;
  logic [IDXW-1:0]   sidx;

  assign sel_ok = (int'(sel) < NSRC);
  assign sidx   = sel[IDXW-1:0];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign lvl_on[g]    = lvl_hit(mode_q[g].trig, in_q[g]);
    assign edge_seen[g] = edge_hit(mode_q[g].trig, irq_req[g], in_q[g]);
    assign sel_hot[g]   = sel_ok && (sidx == IDXW'(g));
    assign ack_hot[g]   = ack && (ack_idx == IDXW'(g));
    assign prio[g]      = mode_q[g].prio;
    assign pend[g]      = flag_q[g] | lvl_on[g];

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
      edge_seen[g] |=> pend[g]); // R10
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      flag_q <= '0;
      in_q   <= '0;
      for (int i = 0; i < NSRC; i++) begin
        mode_q[i] <= '0;
        vec_q[i]  <= '0;
      end
    end else begin
      in_q <= irq_req;
      for (int i = 0; i < NSRC; i++) begin
        if (sel_hot[i] && wr_mode) mode_q[i] <= word_to_mode(wdata[6:0]);
        if (sel_hot[i] && wr_vec)  vec_q[i]  <= wdata;
        if (sel_hot[i] && cmd_en)       en_q[i] <= 1'b1;
        else if (sel_hot[i] && cmd_dis) en_q[i] <= 1'b0;
        // a fresh edge outranks any clear in the same cycle
        if (edge_seen[i] || (sel_hot[i] && cmd_set))       flag_q[i] <= 1'b1;
        else if ((sel_hot[i] && cmd_clr) || ack_hot[i])     flag_q[i] <= 1'b0;
      end
    end
  end

  assign en       = en_q;
  assign sel_mode = sel_ok ? mode_q[sidx] : '0;
  assign sel_vec  = sel_ok ? vec_q[sidx]  : '0;
  assign sel_en   = sel_ok ? en_q[sidx]   : 1'b0;
  assign win_vec  = vec_q[win_idx];
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int NSRC = 128,
  parameter int IDXW = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       pend,
  input  logic [NSRC-1:0]       en,
  input  logic [NSRC-1:0][2:0]  prio,
  input  logic                  stk_empty,
  input  logic [2:0]            stk_top_prio,
  output logic                  found,
  output logic [IDXW-1:0]       win_idx,
  output logic [2:0]            win_prio,
  output logic                  take
);
  // strict compare keeps the lowest index on equal priority
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && en[i] && (!found || prio[i] > win_prio)) begin
        found    = 1'b1;
        win_idx  = IDXW'(i);
        win_prio = prio[i];
      end
    end
  end

  assign take = found && prio_beats(win_prio, stk_empty, stk_top_prio);

  AST_WIN_IS_LIVE: assert property (@(posedge clk) disable iff (rst)
    found |-> (pend[win_idx] && en[win_idx])); // R6
  AST_NO_TAKE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(|(pend & en)) |-> !take); // R6
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
  parameter int DEPTH = 8,
  parameter int IDXW  = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [2:0]      push_prio,
  input  logic [IDXW-1:0] push_idx,
  input  logic            pop,
  output logic            empty,
  output logic [2:0]      top_prio,
  output logic [IDXW-1:0] top_idx
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [CW-1:0]   cnt;
  logic [PW-1:0]   tptr;
  logic            full;
  logic [2:0]      prio_q [DEPTH];
  logic [IDXW-1:0] idx_q  [DEPTH];

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign tptr  = PW'(cnt - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prio_q[i] <= '0;
        idx_q[i]  <= '0;
      end
    end else if (push && !full) begin
      prio_q[cnt[PW-1:0]] <= push_prio;
      idx_q[cnt[PW-1:0]]  <= push_idx;
      cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign top_prio = empty ? 3'd0 : prio_q[tptr];
  assign top_idx  = empty ? '0   : idx_q[tptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R12
  AST_NEST_RISES: assert property (@(posedge clk) disable iff (rst)
    (push && !empty) |-> (push_prio > top_prio)); // R8
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty); // R9
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NSRC  = 128,
  parameter int DW    = 32,
  parameter int NEST  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] irq_req,
  output logic            irq_out
);
  localparam int IDXW = $clog2(NSRC);

  logic [6:0]      sel_q;
  logic [DW-1:0]   spu_q, dbg_q;

  logic [NSRC-1:0]      pend, en;
  logic [NSRC-1:0][2:0] prio;
  src_mode_t            sel_mode;
  logic [DW-1:0]        sel_vec, win_vec;
  logic                 sel_en;

  logic            found, take, ack, pop, stk_empty;
  logic [IDXW-1:0] win_idx, top_idx;
  logic [2:0]      win_prio, top_prio;
  logic [127:0]    pend_pad;

  logic wr_mode, wr_vec, cmd_en, cmd_dis, cmd_clr, cmd_set;

  assign wr_mode = bus_wr && bus_addr == OFF_MODE;
  assign wr_vec  = bus_wr && bus_addr == OFF_VEC;
  assign cmd_en  = bus_wr && bus_addr == OFF_ENA && bus_wdata[0];
  assign cmd_dis = bus_wr && bus_addr == OFF_DIS && bus_wdata[0];
  assign cmd_clr = bus_wr && bus_addr == OFF_CLR && bus_wdata[0];
  assign cmd_set = bus_wr && bus_addr == OFF_SET && bus_wdata[0];
  assign ack     = bus_rd && bus_addr == OFF_ACK && take;
  assign pop     = bus_wr && bus_addr == OFF_EOI;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      spu_q <= '0;
      dbg_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFF_SEL)  sel_q <= bus_wdata[6:0];
      if (bus_addr == OFF_SPUR) spu_q <= bus_wdata;
      if (bus_addr == OFF_DBG)  dbg_q <= bus_wdata;
    end
  end

  vic_src_bank #(.NSRC(NSRC), .DW(DW), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst(rst), .irq_req(irq_req), .sel(sel_q), .wdata(bus_wdata),
    .wr_mode(wr_mode), .wr_vec(wr_vec), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .cmd_clr(cmd_clr), .cmd_set(cmd_set), .ack(ack), .ack_idx(win_idx),
    .win_idx(win_idx), .pend(pend), .en(en), .prio(prio), .sel_mode(sel_mode),
    .sel_vec(sel_vec), .sel_en(sel_en), .win_vec(win_vec)
  );

  vic_arbiter #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .en(en), .prio(prio),
    .stk_empty(stk_empty), .stk_top_prio(top_prio),
    .found(found), .win_idx(win_idx), .win_prio(win_prio), .take(take)
  );

  vic_nest_stack #(.DEPTH(NEST), .IDXW(IDXW)) u_stk (
    .clk(clk), .rst(rst), .push(ack), .push_prio(win_prio), .push_idx(win_idx),
    .pop(pop), .empty(stk_empty), .top_prio(top_prio), .top_idx(top_idx)
  );

  assign irq_out  = take;
  assign pend_pad = 128'(pend);

  always_comb begin
    unique case (bus_addr)
      OFF_SEL:  bus_rdata = DW'(sel_q);
      OFF_MODE: bus_rdata = DW'(mode_to_word(sel_mode));
      OFF_VEC:  bus_rdata = sel_vec;
      OFF_ACK:  bus_rdata = take ? win_vec : spu_q;
      OFF_CUR:  bus_rdata = DW'(top_idx);
      OFF_PND0: bus_rdata = DW'(pend_pad[31:0]);
      OFF_PND1: bus_rdata = DW'(pend_pad[63:32]);
      OFF_PND2: bus_rdata = DW'(pend_pad[95:64]);
      OFF_PND3: bus_rdata = DW'(pend_pad[127:96]);
      OFF_ENRD: bus_rdata = DW'(sel_en);
      OFF_SPUR: bus_rdata = spu_q;
      OFF_DBG:  bus_rdata = dbg_q;
      default:  bus_rdata = '0;
    endcase
  end

  AST_SPUR_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFF_ACK && !irq_out) |-> (bus_rdata == spu_q)); // R7
  AST_ACK_STACKS: assert property (@(posedge clk) disable iff (rst)
    ack |=> !stk_empty); // R8
  AST_FOUND_NEEDED: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> found); // R6
endmodule

// File: tb/tb_vic_top.sv
`timescale 1ns/1ps
module tb_vic_top;
  localparam int NSRC = 128;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NSRC-1:0] irq_req = '0;
  logic        irq_out;

  always #2.5 clk = ~clk;

  vic_top #(.NSRC(NSRC)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_out(irq_out)
  );

  int errors = 0, checks = 0;

  // reference state built from the requirements
  bit [2:0]  m_prio [NSRC];
  bit [1:0]  m_trig [NSRC];
  bit [31:0] m_vec  [NSRC];
  bit        m_en [NSRC], m_flag [NSRC], m_q [NSRC];
  int        sp_prio [8], sp_idx [8], depth;
  bit [6:0]  m_sel;
  bit [31:0] m_spu, m_dbg;
  logic [NSRC-1:0] req_drv = '0;

  task automatic model_init();
    for (int i = 0; i < NSRC; i++) begin
      m_prio[i] = 0; m_trig[i] = 0; m_vec[i] = 0;
      m_en[i] = 0; m_flag[i] = 0; m_q[i] = 0;
    end
    depth = 0; m_sel = 0; m_spu = 0; m_dbg = 0;
  endtask

  function automatic bit m_pend(int i);
    return m_flag[i] || (m_trig[i] == 2'b00 && m_q[i]) || (m_trig[i] == 2'b01 && !m_q[i]);
  endfunction

  function automatic bit m_valid(output int bi);
    bit f = 0;
    bi = 0;
    for (int i = 0; i < NSRC; i++)
      if (m_pend(i) && m_en[i] && (!f || m_prio[i] > m_prio[bi])) begin f = 1; bi = i; end
    return f && (depth == 0 || int'(m_prio[bi]) > sp_prio[depth-1]);
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    int bi;
    bit [31:0] w = 0;
    case (a)
      8'h00: return {25'b0, m_sel};
      8'h04: return {25'b0, m_trig[m_sel], 2'b00, m_prio[m_sel]};
      8'h08: return m_vec[m_sel];
      8'h10: return m_valid(bi) ? m_vec[bi] : m_spu;
      8'h18: return (depth > 0) ? 32'(sp_idx[depth-1]) : 32'd0;
      8'h20, 8'h24, 8'h28, 8'h2C: begin
        for (int b = 0; b < 32; b++) w[b] = m_pend(int'(a[3:2]) * 32 + b);
        return w;
      end
      8'h30: return {31'b0, m_en[m_sel]};
      8'h3C: return m_spu;
      8'h6C: return m_dbg;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(bit [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08: return "R2";
      8'h10, 8'h3C: return "R7";
      8'h18: return "R8";
      8'h20, 8'h24, 8'h28, 8'h2C: return "R4";
      8'h30: return "R3";
      default: return "R11";
    endcase
  endfunction

  task automatic model_step(bit [7:0] a, bit we, bit re, bit [31:0] wd);
    int bi;
    bit v = m_valid(bi);
    for (int i = 0; i < NSRC; i++) begin
      bit edg = (m_trig[i] == 2'b10 && req_drv[i] && !m_q[i]) ||
                (m_trig[i] == 2'b11 && !req_drv[i] && m_q[i]);
      bit hit = (m_sel == 7'(i));
      bit setc = we && a == 8'h4C && wd[0] && hit;
      bit clrc = (we && a == 8'h48 && wd[0] && hit) || (re && a == 8'h10 && v && bi == i);
      if (edg || setc) m_flag[i] = 1;
      else if (clrc)   m_flag[i] = 0;
    end
    if (re && a == 8'h10 && v) begin
      sp_prio[depth] = m_prio[bi]; sp_idx[depth] = bi; depth++;
    end
    if (we) begin
      case (a)
        8'h00: m_sel = wd[6:0];
        8'h04: begin m_prio[m_sel] = wd[2:0]; m_trig[m_sel] = wd[6:5]; end
        8'h08: m_vec[m_sel] = wd;
        8'h40: if (wd[0]) m_en[m_sel] = 1;
        8'h44: if (wd[0]) m_en[m_sel] = 0;
        8'h38: if (depth > 0) depth--;
        8'h3C: m_spu = wd;
        8'h6C: m_dbg = wd;
        default: ;
      endcase
    end
    for (int i = 0; i < NSRC; i++) m_q[i] = req_drv[i];
  endtask

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic cyc(bit [7:0] a, bit we, bit re, bit [31:0] wd, string t);
    int bi;
    @(negedge clk);
    bus_addr = a; bus_wr = we; bus_rd = re; bus_wdata = wd; irq_req = req_drv;
    #1;
    chk("R6 irq_out", {31'b0, irq_out}, {31'b0, m_valid(bi)});
    if (re) chk((t == "") ? tag_of(a) : t, bus_rdata, m_read(a));
    @(posedge clk);
    model_step(a, we, re, wd);
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d); cyc(a, 1, 0, d, ""); endtask
  task automatic rd(bit [7:0] a, string t);     cyc(a, 0, 1, 0, t);  endtask
  task automatic idle();                        cyc(0, 0, 0, 0, ""); endtask

  task automatic cfg(int s, int p, bit [1:0] tr, bit [31:0] v);
    wr(8'h00, s);
    wr(8'h04, {25'b0, tr, 2'b00, 3'(p)});
    wr(8'h08, v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; bus_wr = 0; bus_rd = 0; req_drv = '0; irq_req = '0;
    repeat (2) @(posedge clk);
    model_init();
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int srcs [8] = '{0, 1, 5, 31, 32, 64, 100, 127};
    bit [7:0] maps [10] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h3C};
    bit [7:0] holes [6] = '{8'h0C, 8'h14, 8'h34, 8'h50, 8'h70, 8'hFC};
    void'($urandom(32'd20240611));
    model_init();
    do_reset();

    // R1: reset state
    rd(8'h10, "R1"); rd(8'h18, "R1"); rd(8'h20, "R1"); rd(8'h30, "R1"); rd(8'h04, "R1");

    // R2: indirect storage and 7-bit select
    cfg(9, 5, 2'b01, 32'hCAFE_0009);
    cfg(40, 3, 2'b10, 32'h1234_0040);
    wr(8'h04, 32'hFFFF_FF9B);
    rd(8'h04, "R2");
    wr(8'h00, 9); rd(8'h04, "R2"); rd(8'h08, "R2");
    wr(8'h00, 32'hFF); rd(8'h00, "R2");

    // R3: commands need bit 0
    wr(8'h00, 9); wr(8'h40, 0); rd(8'h30, "R3");
    wr(8'h40, 1); rd(8'h30, "R3");
    wr(8'h44, 1); rd(8'h30, "R3");
    wr(8'h00, 100); wr(8'h4C, 32'hE); rd(8'h2C, "R3");
    wr(8'h4C, 1); rd(8'h2C, "R4");
    wr(8'h48, 1); rd(8'h2C, "R3");

    // R5: level-low, falling-edge
    do_reset();
    cfg(20, 1, 2'b01, 32'h20); idle(); rd(8'h20, "R5");
    req_drv[20] = 1; idle(); rd(8'h20, "R5");
    cfg(21, 1, 2'b11, 32'h21); req_drv[21] = 1; idle(); idle();
    req_drv[21] = 0; idle(); rd(8'h20, "R5");
    req_drv[21] = 1; idle(); rd(8'h20, "R5");

    // R10: edge coincident with acknowledge and with clear
    do_reset();
    wr(8'h3C, 32'h5555_AAAA);
    cfg(3, 2, 2'b10, 32'h33); wr(8'h40, 1);
    req_drv[3] = 1; idle(); req_drv[3] = 0; idle();
    req_drv[3] = 1; rd(8'h10, "R10");
    rd(8'h20, "R10"); rd(8'h10, "R7");
    wr(8'h38, 0);
    req_drv[3] = 0; idle();
    req_drv[3] = 1; wr(8'h48, 1);
    rd(8'h20, "R10");
    wr(8'h48, 1); rd(8'h20, "R3");

    // R7: tie goes to lowest index
    cfg(50, 4, 2'b00, 32'h50); wr(8'h40, 1);
    cfg(45, 4, 2'b00, 32'h45); wr(8'h40, 1);
    req_drv[50] = 1; req_drv[45] = 1; idle();
    rd(8'h10, "R7"); rd(8'h18, "R8");
    wr(8'h38, 0); req_drv[50] = 0; req_drv[45] = 0; idle();

    // R12 / R9: full nesting then release
    do_reset();
    wr(8'h3C, 32'hDEAD_0000);
    for (int k = 0; k < 8; k++) begin
      cfg(10 + k, k, 2'b00, 32'h100 + k);
      req_drv[10 + k] = 1; wr(8'h40, 1); idle();
      rd(8'h10, "R8");
    end
    rd(8'h18, "R12"); rd(8'h10, "R12");
    for (int k = 0; k < 8; k++) wr(8'h38, $urandom);
    rd(8'h18, "R9");
    wr(8'h38, 0); rd(8'h18, "R9");
    rd(8'h10, "R7");

    // R11: storage word and holes
    wr(8'h6C, 32'hA5A5_0F0F); rd(8'h6C, "R11");
    wr(8'h5C, 32'hFFFF_FFFF); rd(8'h5C, "R11"); rd(8'h6C, "R11");

    // constrained random traffic
    do_reset();
    wr(8'h3C, 32'h0BAD_F00D);
    for (int n = 0; n < 3000; n++) begin
      int s = srcs[$urandom_range(0, 7)];
      case ($urandom_range(0, 11))
        0:  wr(8'h00, s);
        1:  wr(8'h04, $urandom);
        2:  wr(8'h08, $urandom);
        3:  wr(8'h40, $urandom_range(0, 3));
        4:  wr(8'h44, $urandom_range(0, 1) & $urandom_range(0, 1));
        5:  wr(8'h48, $urandom_range(0, 1));
        6:  wr(8'h4C, $urandom_range(0, 1));
        7:  begin req_drv[s] = ~req_drv[s]; idle(); end
        8:  rd(8'h10, "");
        9:  wr(8'h38, $urandom);
        10: rd(maps[$urandom_range(0, 9)], "");
        default: begin
          bit [7:0] h = holes[$urandom_range(0, 5)];
          if ($urandom_range(0, 1)) wr(h, $urandom); else rd(h, "R11");
        end
      endcase
    end
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule